// File: doc/BRIEF.md
# Control Register Bank with Soft Reset

This block is a small host-visible register bank that sits beside a bus target and owns the chip's software-controlled reset. It holds a run/reset bit, a wait-state count for the bus target, a direction byte and a data byte for eight general purpose pins, and a 32-bit DMA code base address. A plain register port carries the host traffic: a byte address, four byte enables, write data and combinational read data. An asynchronous active-low power-on reset initialises everything.

The run bit is the master gate. While it is 0, every other register is forced to its default and ignores host writes. The bank itself stays reachable, so the host can set the bit back to 1. A registered, active-high internal reset derived from the bit is driven to the rest of the chip. The general purpose pins are modelled as output value, output enable and input level. Input levels pass through a synchronizer before they can be read back. Each pin reads its live synchronized level when it is an input and its driven value when it is an output.

Top module: `ctrl_regbank`

## Requirements
- R1: After power-on reset the run bit is 0, core_rst is 1, wait_states is 0, the direction byte is 0xFF (gpio_oe = 0x00), gpio_o is 0xF0 and dma_base is 0xFFFFFFFC.
- R2: The run bit is bit 24 of the word at byte address 0x28. It is written when byte enable 3 is set, in any state, and 1 means run and 0 means reset.
- R3: While the run bit is 0, the wait-state, direction, GPIO data and DMA registers are loaded with their defaults on every clock and ignore writes. This includes a write that sets the run bit in the same cycle.
- R4: core_rst is a register that equals the inverse of the run bit one clock earlier.
- R5: At 0x28, bits 18:16 (byte lane 2) hold wait_states and bits 7:0 (byte lane 0) hold the direction byte, with 1 meaning input. gpio_oe is the bitwise inverse of the direction byte.
- R6: At 0x2C, a write with byte enable 3 copies wdata bits 31:24 into gpio_o only for pins whose direction bit is 0. Bits of input pins keep their value.
- R7: A read of 0x2C returns in bits 31:24, for each pin, the input level if it is an input and the gpio_o value if it is an output. The input level is the gpio_i value delayed through two clocked stages.
- R8: At 0x30, dma_base is written byte lane by byte lane, and bits 1:0 always read 0.
- R9: Reserved bits (0x28 bits 31:25, 23:19, 15:8 and 0x2C bits 23:0) read 0. Reads of any other address return 0, and writes to it change nothing.
- R10: A write that clears the run bit while running still applies its other fields on that edge. All gated registers then return to defaults on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address of the access |
| be | input | 4 | Byte enables for the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| core_rst | output | 1 | Registered internal reset, active high |
| wait_states | output | 3 | Wait-state count for the bus target |
| gpio_i | input | 8 | Pin input levels (asynchronous) |
| gpio_o | output | 8 | Pin output values |
| gpio_oe | output | 8 | Pin output enables, 1 drives the pin |
| dma_base | output | 32 | DMA code base address |

## Verification
The run bit and the other fields of the same control word can be written on the same edge. This case is provoked in both directions. A write that sets run while other fields change must leave those fields at their defaults. A write that clears run while changing the wait-state field must show the new value for exactly one cycle before it falls back to its default. A behavioural model in the bench tracks run, the gated registers and the synchronizer stages. It is compared with every output and with the read data on every clock, through directed sequences, a long random phase with mixed byte enables, and power-on resets that arrive mid-run.

// File: rtl/ctrl_regbank_pkg.sv
package ctrl_regbank_pkg;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned LANES    = DATA_W / 8;

   localparam logic [31:0] OFF_CTRL = 32'h0000_0028;
   localparam logic [31:0] OFF_GPIO = 32'h0000_002C;
   localparam logic [31:0] OFF_DMA  = 32'h0000_0030;

   localparam int unsigned RUN_BIT  = 24;
   localparam int unsigned WS_LSB   = 16;
   localparam int unsigned DIR_LSB  = 0;
   localparam int unsigned PIN_LSB  = 24;

   localparam logic [7:0]  PIN_DEFAULT = 8'hF0;
   localparam logic [31:0] DMA_DEFAULT = 32'hFFFF_FFFC;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_GPIO,
      SEL_DMA
   } reg_sel_e;

   function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
      logic [DATA_W-1:0] m;
      for (int k = 0; k < LANES; k++) begin
         m[8*k +: 8] = {8{be[k]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/rb_field.sv
module rb_field #(
   parameter int unsigned   W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         hold,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("rb_field: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_next;

   always_comb begin
      if (hold) q_next = RST_VAL;
      else      q_next = (q & ~wmask) | (wdata & wmask);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q <= RST_VAL;
      else        q <= q_next;
   end

endmodule

// File: rtl/rb_sync.sv
module rb_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stage[0] <= '0;
               else        stage[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];

endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
   import ctrl_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned WS_W        = 3,
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DMA_ZERO_LSBS = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              core_rst,
   output logic [WS_W-1:0]   wait_states,
   input  logic [PIN_W-1:0]  gpio_i,
   output logic [PIN_W-1:0]  gpio_o,
   output logic [PIN_W-1:0]  gpio_oe,
   output logic [DATA_W-1:0] dma_base
);

   localparam logic [ADDR_W-1:0] A_CTRL = OFF_CTRL[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_GPIO = OFF_GPIO[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_DMA  = OFF_DMA[ADDR_W-1:0];
   localparam logic [PIN_W-1:0]  PIN_RST = PIN_DEFAULT[PIN_W-1:0];
   localparam logic [PIN_W-1:0]  DIR_RST = '1;
   localparam logic [DATA_W-1:0] DMA_KEEP = ~((DATA_W'(1) << DMA_ZERO_LSBS) - DATA_W'(1));

   generate
      if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
         $error("ctrl_regbank: ADDR_W must lie in 6..32");
      end
      if (WS_W < 1 || WS_W > 8) begin : g_bad_ws
         $error("ctrl_regbank: WS_W must lie in 1..8");
      end
      if (PIN_W < 1 || PIN_W > 8) begin : g_bad_pin
         $error("ctrl_regbank: PIN_W must lie in 1..8");
      end
      if (DMA_ZERO_LSBS > 8) begin : g_bad_dma
         $error("ctrl_regbank: DMA_ZERO_LSBS must not exceed 8");
      end
   endgenerate

   // address decode
   reg_sel_e sel;
   always_comb begin
      if      (addr == A_CTRL) sel = SEL_CTRL;
      else if (addr == A_GPIO) sel = SEL_GPIO;
      else if (addr == A_DMA)  sel = SEL_DMA;
      else                     sel = SEL_NONE;
   end

   // run bit: written in every state, owns the gate for everything else
   logic run_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                    run_q <= 1'b0;
      else if (wr_en && sel == SEL_CTRL && be[RUN_BIT/8]) run_q <= wdata[RUN_BIT];
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) core_rst <= 1'b1;
      else        core_rst <= ~run_q;
   end

   logic              hold;
   logic [DATA_W-1:0] wm_all;
   logic [DATA_W-1:0] wm_ctrl, wm_gpio, wm_dma;

   assign hold    = ~run_q;
   assign wm_all  = (wr_en && run_q) ? lane_mask(be) : '0;
   assign wm_ctrl = (sel == SEL_CTRL) ? wm_all : '0;
   assign wm_gpio = (sel == SEL_GPIO) ? wm_all : '0;
   assign wm_dma  = (sel == SEL_DMA)  ? wm_all : '0;

   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] pin_q;
   logic [PIN_W-1:0] pin_sync;

   rb_field #(.W(WS_W), .RST_VAL('0)) u_ws (
      .clk   (clk),
      .por_n (por_n),
      .hold  (hold),
      .wmask (wm_ctrl[WS_LSB +: WS_W]),
      .wdata (wdata[WS_LSB +: WS_W]),
      .q     (wait_states)
   );

   rb_field #(.W(PIN_W), .RST_VAL(DIR_RST)) u_dir (
      .clk   (clk),
      .por_n (por_n),
      .hold  (hold),
      .wmask (wm_ctrl[DIR_LSB +: PIN_W]),
      .wdata (wdata[DIR_LSB +: PIN_W]),
      .q     (dir_q)
   );

   rb_field #(.W(PIN_W), .RST_VAL(PIN_RST)) u_pin (
      .clk   (clk),
      .por_n (por_n),
      .hold  (hold),
      .wmask (wm_gpio[PIN_LSB +: PIN_W] & ~dir_q),
      .wdata (wdata[PIN_LSB +: PIN_W]),
      .q     (pin_q)
   );

   rb_field #(.W(DATA_W), .RST_VAL(DMA_DEFAULT & DMA_KEEP)) u_dma (
      .clk   (clk),
      .por_n (por_n),
      .hold  (hold),
      .wmask (wm_dma & DMA_KEEP),
      .wdata (wdata),
      .q     (dma_base)
   );

   rb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (gpio_i),
      .q     (pin_sync)
   );

   assign gpio_o  = pin_q;
   assign gpio_oe = ~dir_q;

   // read mux
   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            rdata[RUN_BIT]           = run_q;
            rdata[WS_LSB +: WS_W]    = wait_states;
            rdata[DIR_LSB +: PIN_W]  = dir_q;
         end
         SEL_GPIO: rdata[PIN_LSB +: PIN_W] = (dir_q & pin_sync) | (~dir_q & pin_q);
         SEL_DMA:  rdata = dma_base;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/ctrl_regbank_chk.sv
module ctrl_regbank_chk
   import ctrl_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WS_W   = 3,
   parameter int unsigned PIN_W  = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [LANES-1:0]  be,
   input logic              wdata_run,
   input logic [DATA_W-1:0] rdata,
   input logic              core_rst,
   input logic [WS_W-1:0]   wait_states,
   input logic [PIN_W-1:0]  gpio_o,
   input logic [PIN_W-1:0]  gpio_oe,
   input logic [1:0]        dma_low,
   input logic              run_q
);

   logic known;
   assign known = (addr == OFF_CTRL[ADDR_W-1:0]) || (addr == OFF_GPIO[ADDR_W-1:0]) ||
                  (addr == OFF_DMA[ADDR_W-1:0]);

   // R1
   por_defaults_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(por_n) |-> (core_rst && !run_q && wait_states == '0 && gpio_oe == '0));

   // R2
   run_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && addr == OFF_CTRL[ADDR_W-1:0] && be[3]) |=> (run_q == $past(wdata_run)));

   // R3
   held_default_chk: assert property (@(posedge clk) disable iff (!por_n)
      !run_q |=> (wait_states == '0 && gpio_oe == '0 &&
                  gpio_o == PIN_DEFAULT[PIN_W-1:0]));

   // R4
   core_rst_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> (core_rst == !$past(run_q)));

   // R6
   input_pin_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (run_q && wr_en && addr == OFF_GPIO[ADDR_W-1:0]) |=>
         (((gpio_o ^ $past(gpio_o)) & ~$past(gpio_oe)) == '0));

   // R8
   dma_low_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      dma_low == 2'b00);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      !known |-> (rdata == '0));

   // R9
   ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!por_n)
      (addr == OFF_CTRL[ADDR_W-1:0]) |-> (rdata[31:25] == '0 && rdata[15:8] == '0));

endmodule

bind ctrl_regbank ctrl_regbank_chk #(
   .ADDR_W (ADDR_W),
   .WS_W   (WS_W),
   .PIN_W  (PIN_W)
) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .be          (be),
   .wdata_run   (wdata[24]),
   .rdata       (rdata),
   .core_rst    (core_rst),
   .wait_states (wait_states),
   .gpio_o      (gpio_o),
   .gpio_oe     (gpio_oe),
   .dma_low     (dma_base[1:0]),
   .run_q       (run_q)
);

// File: tb/tb_ctrl_regbank.sv
`timescale 1ns/1ps
module tb_ctrl_regbank;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [3:0]  be = 4'h0;
   logic [31:0] wdata = 32'h0;
   logic [7:0]  gpio_i = 8'h00;
   logic [31:0] rdata;
   logic        core_rst;
   logic [2:0]  wait_states;
   logic [7:0]  gpio_o, gpio_oe;
   logic [31:0] dma_base;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctrl_regbank dut (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .be(be),
      .wdata(wdata), .rdata(rdata), .core_rst(core_rst),
      .wait_states(wait_states), .gpio_i(gpio_i), .gpio_o(gpio_o),
      .gpio_oe(gpio_oe), .dma_base(dma_base)
   );

   // behavioural reference model
   bit        m_run = 0;
   bit        m_rst = 1;
   bit [2:0]  m_ws = 0;
   bit [7:0]  m_dir = 8'hFF;
   bit [7:0]  m_out = 8'hF0;
   bit [31:0] m_dma = 32'hFFFF_FFFC;
   bit [7:0]  m_s1 = 0, m_s2 = 0;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_run = 0; m_rst = 1; m_ws = 0; m_dir = 8'hFF; m_out = 8'hF0;
         m_dma = 32'hFFFF_FFFC; m_s1 = 0; m_s2 = 0;
      end else begin
         bit old_run;
         bit [7:0] old_dir;
         old_run = m_run;
         old_dir = m_dir;
         if (wr_en && addr == 8'h28 && be[3]) m_run = wdata[24];
         m_rst = !old_run;
         if (old_run) begin
            if (wr_en && addr == 8'h28) begin
               if (be[2]) m_ws = wdata[18:16];
               if (be[0]) m_dir = wdata[7:0];
            end
            if (wr_en && addr == 8'h2C && be[3])
               for (int i = 0; i < 8; i++) if (!old_dir[i]) m_out[i] = wdata[24+i];
            if (wr_en && addr == 8'h30)
               for (int k = 0; k < 4; k++) if (be[k]) m_dma[8*k +: 8] = wdata[8*k +: 8];
            m_dma[1:0] = 2'b00;
         end else begin
            m_ws = 0; m_dir = 8'hFF; m_out = 8'hF0; m_dma = 32'hFFFF_FFFC;
         end
         m_s2 = m_s1;
         m_s1 = gpio_i;
      end
   end

   function automatic bit [31:0] exp_rdata();
      if (addr == 8'h28) return {7'd0, m_run, 5'd0, m_ws, 8'd0, m_dir};
      if (addr == 8'h2C) return {((m_dir & m_s2) | (~m_dir & m_out)), 24'd0};
      if (addr == 8'h30) return m_dma;
      return 32'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en && por_n) begin
         chk("R4 core_rst", {31'd0, core_rst}, {31'd0, m_rst});
         chk("R5 wait_states", {29'd0, wait_states}, {29'd0, m_ws});
         chk("R5 gpio_oe", {24'd0, gpio_oe}, {24'd0, ~m_dir});
         chk("R6 gpio_o", {24'd0, gpio_o}, {24'd0, m_out});
         chk("R8 dma_base", dma_base, m_dma);
         if (addr == 8'h2C)      chk("R7 rdata", rdata, exp_rdata());
         else if (addr == 8'h28) chk("R2 rdata", rdata, exp_rdata());
         else if (addr == 8'h30) chk("R8 rdata", rdata, exp_rdata());
         else                    chk("R9 rdata", rdata, exp_rdata());
      end
   end

   task automatic drive(input logic w, input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d);
      @(posedge clk); #2;
      wr_en = w; addr = a; be = b; wdata = d;
   endtask

   task automatic at_mid();
      @(negedge clk); #1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 por_n = 1'b1; cmp_en = 1'b1;
      drive(0, 8'h28, 4'h0, 0);
      at_mid();
      chk("R1 ctrl", rdata, 32'h0000_00FF);
      chk("R1 core_rst", {31'd0, core_rst}, 32'd1);
      chk("R1 gpio_o", {24'd0, gpio_o}, 32'hF0);
      chk("R1 gpio_oe", {24'd0, gpio_oe}, 32'h00);
      chk("R1 dma", dma_base, 32'hFFFF_FFFC);

      // run set together with other fields: only run lands
      drive(1, 8'h28, 4'hF, 32'h0107_00AA);
      drive(0, 8'h28, 4'h0, 0);
      at_mid();
      chk("R2 run set", rdata, 32'h0100_00FF);
      chk("R3 ws gated", {29'd0, wait_states}, 32'd0);
      chk("R4 core_rst lag", {31'd0, core_rst}, 32'd1);
      at_mid();
      chk("R4 core_rst low", {31'd0, core_rst}, 32'd0);

      drive(1, 8'h28, 4'hF, 32'h0107_00AA);
      drive(0, 8'h28, 4'h0, 0);
      at_mid();
      chk("R5 ctrl", rdata, 32'h0107_00AA);
      chk("R5 ws", {29'd0, wait_states}, 32'd7);
      chk("R5 oe", {24'd0, gpio_oe}, 32'h55);

      drive(1, 8'h2C, 4'h8, 32'hFF00_0000);
      drive(0, 8'h2C, 4'h0, 0);
      at_mid();
      chk("R6 outputs only", {24'd0, gpio_o}, 32'hF5);
      chk("R7 mixed read", rdata, 32'h5500_0000);
      gpio_i = 8'hFF;
      at_mid();
      chk("R7 sync latency", rdata, 32'h5500_0000);
      at_mid();
      chk("R7 sync arrives", rdata, 32'hFF00_0000);

      drive(1, 8'h30, 4'b0101, 32'h1234_5677);
      drive(0, 8'h30, 4'h0, 0);
      at_mid();
      chk("R8 lanes", rdata, 32'hFF34_FF74);

      drive(1, 8'h34, 4'hF, 32'hFFFF_FFFF);
      drive(0, 8'h34, 4'h0, 0);
      at_mid();
      chk("R9 unmapped", rdata, 32'h0);
      drive(0, 8'h2A, 4'h0, 0);
      at_mid();
      chk("R9 unaligned", rdata, 32'h0);

      // clear run while writing the wait field
      drive(1, 8'h28, 4'b1100, 32'h0002_0000);
      drive(0, 8'h28, 4'h0, 0);
      at_mid();
      chk("R10 applied", {29'd0, wait_states}, 32'd2);
      at_mid();
      chk("R10 defaulted", {29'd0, wait_states}, 32'd0);
      chk("R10 ctrl", rdata, 32'h0000_00FF);
      chk("R10 core_rst", {31'd0, core_rst}, 32'd1);

      drive(1, 8'h2C, 4'hF, 32'h0);
      drive(1, 8'h30, 4'hF, 32'h0);
      drive(0, 8'h30, 4'h0, 0);
      at_mid();
      chk("R3 gpio held", {24'd0, gpio_o}, 32'hF0);
      chk("R3 dma held", dma_base, 32'hFFFF_FFFC);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] a;
         logic [31:0] d;
         case ($urandom_range(0, 5))
            0, 1: a = 8'h28;
            2:    a = 8'h2C;
            3:    a = 8'h30;
            4:    a = 8'h34;
            default: a = 8'h00;
         endcase
         d = $urandom;
         if (a == 8'h28 && $urandom_range(0, 7) != 0) d[24] = 1'b1;
         drive($urandom_range(0, 1) == 1, a, 4'($urandom), d);
         if ($urandom_range(0, 3) == 0) gpio_i = 8'($urandom);
         if ($urandom_range(0, 400) == 0) begin
            por_n = 1'b0;
            @(posedge clk); #2 por_n = 1'b1;
         end
      end
      drive(0, 8'h00, 4'h0, 0);
      at_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule